// File: doc/BRIEF.md
# Residue to Binary Converter for the (8,7,5,3) Residue System

This block turns a four-digit residue number back into an ordinary unsigned binary integer. The four digits are the remainders of the value modulo 8, 7, 5 and 3. Together they cover a dynamic range of 840, so the result always lies between 0 and 839. The block sends each digit through a fixed Chinese-Remainder position weight and adds up the four weighted terms. A single modular reduction then brings the sum into range.

A caller presents the four digits with `in_valid` high for one cycle. On the next clock the binary value appears on `out_value` with `out_valid` high. The output register keeps the last result until the next accepted input. A parameter chooses how each weighted term is formed: either a per-digit lookup that holds one entry per legal digit value (23 entries across all four digits), or a constant multiplier. Both forms give the same result.

Top module: `rns_to_bin`

## Requirements
- R1: The digit on `res8` is the value modulo 8, `res7` modulo 7, `res5` modulo 5 and `res3` modulo 3. For legal digits, a valid result is the unique integer from 0 to 839 with exactly those four remainders.
- R2: The result equals (res8·105 + res7·120 + res5·336 + res3·280) mod 840.
- R3: Whenever `out_valid` is high, `out_value` is below 840. This holds even for the largest legal tuple, (7,6,4,2), whose weighted sum of 3359 needs three subtractions of 840 to give 839.
- R4: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R5: While `in_valid` is low, `out_value` keeps its last value, whatever the digit inputs carry.
- R6: While `rst_n` is low, `out_valid` and `out_value` are both zero.
- R7: The tuples (res8,res7,res5,res3) = (1,2,4,0), (0,0,0,0), (1,1,1,1), (2,2,2,2) and (0,1,3,2) convert to 9, 0, 1, 2 and 8.
- R8: Converting the remainders of every integer from 0 to 839 returns that integer.
- R9: The table form (`USE_TABLE`=1) and the multiplier form (`USE_TABLE`=0) produce identical outputs for identical inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Digits on the residue inputs are to be converted |
| res8 | input | 3 | Residue modulo 8 |
| res7 | input | 3 | Residue modulo 7 |
| res5 | input | 3 | Residue modulo 5 |
| res3 | input | 2 | Residue modulo 3 |
| out_valid | output | 1 | Result registered from the previous cycle's input |
| out_value | output | 10 | Binary result, 0 to 839 |

## Verification
The assertions assume that every digit sampled with `in_valid` high is below its own modulus. The residue-consistency property checks the registered result modulo each modulus against the accepted digits, and a digit out of range would break it on a correct design. The stimulus always builds accepted digits either from the remainders of an integer from 0 to 839 or from a random draw limited per modulus. It puts arbitrary, possibly out-of-range values on the digit inputs only in cycles where `in_valid` is low, which are the cycles used to test that the output holds.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int unsigned NDIG  = 4;
    localparam int unsigned MODS    [NDIG] = '{8, 7, 5, 3};
    localparam int unsigned WEIGHTS [NDIG] = '{105, 120, 336, 280};
    localparam int unsigned RANGE = MODS[0] * MODS[1] * MODS[2] * MODS[3];
    localparam int unsigned DIG_W = 3;
    localparam int unsigned OUT_W = $clog2(RANGE);
    localparam int unsigned SUM_W = $clog2(NDIG * RANGE);
    localparam int unsigned NSUB  = NDIG - 1;
endpackage

// File: rtl/crt_term.sv
module crt_term #(
    parameter int unsigned DW        = 3,
    parameter int unsigned TW        = 12,
    parameter int unsigned MOD       = 8,
    parameter int unsigned WEIGHT    = 105,
    parameter bit          USE_TABLE = 1'b1
) (
    input  logic [DW-1:0] digit,
    output logic [TW-1:0] term
);
    generate
        if (USE_TABLE) begin : g_table
            // one entry per legal digit value
            always_comb begin
                term = '0;
                for (int k = 0; k < int'(MOD); k++) begin
                    if (digit == DW'(k))
                        term = TW'(k * int'(WEIGHT));
                end
            end
        end else begin : g_mult
            always_comb term = TW'(digit) * TW'(WEIGHT);
        end
    endgenerate
endmodule

// File: rtl/crt_reduce.sv
module crt_reduce #(
    parameter int unsigned IN_W  = 12,
    parameter int unsigned OUT_W = 10,
    parameter int unsigned RANGE = 840,
    parameter int unsigned NSUB  = 3
) (
    input  logic [IN_W-1:0]  raw,
    output logic [OUT_W-1:0] value
);
    logic [IN_W-1:0] stage [NSUB+1];

    assign stage[0] = raw;

    genvar s;
    generate
        for (s = 0; s < int'(NSUB); s++) begin : g_sub
            assign stage[s+1] = (stage[s] >= IN_W'(RANGE)) ?
                                stage[s] - IN_W'(RANGE) : stage[s];
        end
    endgenerate

    assign value = OUT_W'(stage[NSUB]);
endmodule

// File: rtl/rns_to_bin.sv
module rns_to_bin
    import crt_pkg::*;
#(
    parameter bit USE_TABLE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [2:0] res8,
    input  logic [2:0] res7,
    input  logic [2:0] res5,
    input  logic [1:0] res3,
    output logic       out_valid,
    output logic [9:0] out_value
);
    logic [DIG_W-1:0] digit [NDIG];
    logic [SUM_W-1:0] term  [NDIG];
    logic [SUM_W-1:0] raw_sum;
    logic [OUT_W-1:0] reduced;

    assign digit[0] = res8;
    assign digit[1] = res7;
    assign digit[2] = res5;
    assign digit[3] = {1'b0, res3};

    genvar i;
    generate
        for (i = 0; i < int'(NDIG); i++) begin : g_digit
            crt_term #(
                .DW(DIG_W), .TW(SUM_W), .MOD(MODS[i]),
                .WEIGHT(WEIGHTS[i]), .USE_TABLE(USE_TABLE)
            ) u_term (
                .digit(digit[i]),
                .term (term[i])
            );
        end
    endgenerate

    always_comb begin
        raw_sum = '0;
        for (int k = 0; k < int'(NDIG); k++)
            raw_sum = raw_sum + term[k];
    end

    crt_reduce #(
        .IN_W(SUM_W), .OUT_W(OUT_W), .RANGE(RANGE), .NSUB(NSUB)
    ) u_reduce (
        .raw  (raw_sum),
        .value(reduced)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_value <= reduced;
        end
    end
endmodule

// File: rtl/rns_to_bin_chk.sv
module rns_to_bin_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [2:0] res8,
    input logic [2:0] res7,
    input logic [2:0] res5,
    input logic [1:0] res3,
    input logic       out_valid,
    input logic [9:0] out_value
);
    p_valid_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_value < 10'd840));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_value));

    // R1: each modulus of the result matches the accepted digit
    p_residues_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (int'(out_value) % 8 == int'($past(res8))) &&
                     (int'(out_value) % 7 == int'($past(res7))) &&
                     (int'(out_value) % 5 == int'($past(res5))) &&
                     (int'(out_value) % 3 == int'($past(res3))));

    // R6: zero state while in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_r6: assert (!out_valid && out_value == 10'd0);
        end
    end
endmodule

bind rns_to_bin rns_to_bin_chk u_chk (.*);

// File: tb/sim_rns_to_bin.sv
`timescale 1ns/1ps
module sim_rns_to_bin;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] res8 = '0, res7 = '0, res5 = '0;
    logic [1:0] res3 = '0;
    logic       ov0, ov1;
    logic [9:0] val0, val1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rns_to_bin #(.USE_TABLE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .res8(res8), .res7(res7), .res5(res5), .res3(res3),
        .out_valid(ov0), .out_value(val0));

    rns_to_bin #(.USE_TABLE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .res8(res8), .res7(res7), .res5(res5), .res3(res3),
        .out_valid(ov1), .out_value(val1));

    // independent model: search for the integer with these remainders
    function automatic int crt_expect(int a8, int a7, int a5, int a3);
        for (int x = 0; x < 840; x++)
            if (x % 8 == a8 && x % 7 == a7 && x % 5 == a5 && x % 3 == a3)
                return x;
        return -1;
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // drive one tuple, sample one cycle later away from the edge
    task automatic convert(int a8, int a7, int a5, int a3, string req, int expected);
        @(negedge clk);
        res8 = 3'(a8); res7 = 3'(a7); res5 = 3'(a5); res3 = 2'(a3);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid R4"}, int'(ov0), 1);
        check(req, int'(val0), expected);
        check({req, " variant R9"}, int'(val1), int'(val0));
        check({req, " valid variant R9"}, int'(ov1), int'(ov0));
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R6 reset valid", int'(ov0), 0);
        check("R6 reset value", int'(val0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 idle valid", int'(ov0), 0);

        // R7 directed tuples
        convert(1, 2, 4, 0, "R7 (1,2,4,0)", 9);
        convert(0, 0, 0, 0, "R7 (0,0,0,0)", 0);
        convert(1, 1, 1, 1, "R7 (1,1,1,1)", 1);
        convert(2, 2, 2, 2, "R7 (2,2,2,2)", 2);
        convert(0, 1, 3, 2, "R7 (0,1,3,2)", 8);
        // R3 largest tuple, three subtractions
        convert(7, 6, 4, 2, "R3 max tuple", 839);

        // R5: digits change while in_valid low, output holds
        @(negedge clk);
        res8 = 3'd7; res7 = 3'd7; res5 = 3'd7; res3 = 2'd3;
        @(negedge clk);
        check("R5 hold value", int'(val0), 839);
        check("R4 valid low", int'(ov0), 0);
        res8 = 3'd3; res7 = 3'd5;
        @(negedge clk);
        check("R5 hold value again", int'(val0), 839);

        // R8 round trip over the whole range
        for (int v = 0; v < 840; v++)
            convert(v % 8, v % 7, v % 5, v % 3, "R8 round trip", v);

        // R1/R2 random legal tuples against the search model
        for (int n = 0; n < 300; n++) begin
            int a8, a7, a5, a3, w;
            a8 = int'($urandom % 8);
            a7 = int'($urandom % 7);
            a5 = int'($urandom % 5);
            a3 = int'($urandom % 3);
            w  = (a8 * 105 + a7 * 120 + a5 * 336 + a3 * 280) % 840;
            check("R2 weighted sum model", w, crt_expect(a8, a7, a5, a3));
            convert(a8, a7, a5, a3, "R1 random", crt_expect(a8, a7, a5, a3));
        end

        // back-to-back strobes keep valid high
        @(negedge clk);
        res8 = 3'd1; res7 = 3'd2; res5 = 3'd4; res3 = 2'd0;
        in_valid = 1'b1;
        @(negedge clk);
        res8 = 3'd0; res7 = 3'd1; res5 = 3'd3; res3 = 2'd2;
        check("R4 stream first", int'(val0), 9);
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 stream second valid", int'(ov0), 1);
        check("R4 stream second", int'(val0), 8);
        @(negedge clk);
        check("R4 stream end", int'(ov0), 0);

        finish_run();
    end
endmodule